// File: doc/BRIEF.md
# Clock output divider channel

This block produces one configurable output clock. A three-bit source code picks one of four internal clocks: the reference, or one of three PLL clocks. For each PLL clock the code can also pick the inverted phase. The chosen clock then goes through a linear divider that takes any integer ratio from 1 to 127. Odd ratios are shaped so that the output is high for half of its period.

A ratio of zero, the reserved source code, a selected PLL that is disabled, or a cleared output enable all turn the output off. The block reports this on an output-enable flag, which a pad wrapper uses to put the pin in high-impedance. While the flag is low, the clock output is held low.

A second, simpler output divides the PLL1 true phase by 2, 3 or 4, or is turned off, under a two-bit code. It uses the same shaping rules and the same enable rules. When a channel starts from the off state, its counter starts fresh. The first output period is therefore complete.

Top module: `clkdiv_channel`

## Requirements
- R1: With a ratio N from 1 to 127 on `divVal`, the `clkOut` period equals N periods of the selected source clock.
- R2: `clkOut` is high for N/2 source periods. For odd N this means a half-period extension. With N = 1 the output follows the selected source waveform.
- R3: With `divVal` = 0, `clkOe` is low, `clkOut` stays low and the divider counter is held cleared.
- R4: Source code on `srcSel`: 000 reference, 010 PLL1 true, 011 PLL1 inverted, 100 PLL2 true, 101 PLL2 inverted, 110 PLL3 true, 111 PLL3 inverted. A rising edge of `clkOut` coincides with a rising edge of the PLL clock for true phase and with a falling edge for inverted phase.
- R5: Source code 001 is reserved. It turns the channel off in the same way as a zero ratio.
- R6: With `outEn` low, `clkOe` and `auxOe` are low and both outputs stay low. The dividers keep their configuration, so raising `outEn` again gives the same ratio and duty cycle.
- R7: `pllEn` bit 0 enables PLL1, bit 1 PLL2 and bit 2 PLL3. A channel whose selected PLL is disabled turns off. A channel on the reference is not affected by `pllEn`.
- R8: `auxSel` selects the auxiliary ratio applied to PLL1 true phase: 00 off, 01 divide by 4, 10 divide by 2, 11 divide by 3. The output is high for half of its period. It is also off when PLL1 is disabled.
- R9: After the channel turns on from off, `clkOut` rises on the first rising edge of the selected source. Its first high time is the full N/2 source periods.
- R10: While `rstN` is low, both enable flags and both clock outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock source |
| pll1Clk | input | 1 | PLL1 output clock |
| pll2Clk | input | 1 | PLL2 output clock |
| pll3Clk | input | 1 | PLL3 output clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pllEn | input | 3 | PLL enable flags, bit 0 = PLL1 |
| srcSel | input | 3 | Source and phase code for the main channel |
| divVal | input | 7 | Main divide ratio, 0 = off |
| auxSel | input | 2 | Auxiliary divider code |
| outEn | input | 1 | Output enable shared by both channels |
| clkOut | output | 1 | Divided main clock |
| clkOe | output | 1 | Pad enable for the main clock |
| auxOut | output | 1 | Divided auxiliary clock |
| auxOe | output | 1 | Pad enable for the auxiliary clock |

## Verification
The hardest case to reach is the half-period extension on odd ratios while the inverted phase of a PLL drives the channel. Here the falling-edge register of the divider works on the rising edge of the raw PLL clock. Errors show up only as a timing shift of a fraction of a source period. To reach it, the stimulus sweeps every ratio from 1 to 127 on the reference and on the PLL1 inverted phase, and a shorter range on the other sources. Each point passes through the off state, and period, high time and the phase of the raw source are measured at the first settled output edge.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int DIV_W = 7;
  localparam int SRC_N = 4;
  localparam int SEL_W = $clog2(SRC_N);
  localparam int PLL_N = SRC_N - 1;

  // Strobes from control to one divider core
  typedef struct packed {
    logic             run;
    logic             oe;
    logic [SEL_W-1:0] srcIdx;
    logic             invert;
    logic             bypass;
    logic             odd;
    logic [DIV_W-1:0] lastIdx;
    logic [DIV_W-1:0] halfCnt;
  } divCmd_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
`timescale 1ns/1ps
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic             rstN,
  input  logic [PLL_N-1:0] pllEn,
  input  logic [2:0]       srcSel,
  input  logic [DIV_W-1:0] divVal,
  input  logic [1:0]       auxSel,
  input  logic             outEn,
  output divCmd_t          mainCmd,
  output divCmd_t          auxCmd
);
  localparam logic [DIV_W-1:0] RATIO_ONE = DIV_W'(1);

  function automatic divCmd_t mkCmd(input logic [DIV_W-1:0] ratio,
                                    input logic [SEL_W-1:0] idx,
                                    input logic inv,
                                    input logic srcOk,
                                    input logic live,
                                    input logic enable);
    divCmd_t c;
    c.run     = live && srcOk && (ratio != '0);
    c.oe      = c.run && enable;
    c.srcIdx  = idx;
    c.invert  = inv;
    c.bypass  = (ratio == RATIO_ONE);
    c.odd     = ratio[0];
    c.lastIdx = ratio - RATIO_ONE;
    c.halfCnt = ratio >> 1;
    return c;
  endfunction

  logic [SEL_W-1:0] mainIdx;
  logic             reservedCode;
  logic             mainInv;
  logic             mainSrcOk;
  logic [DIV_W-1:0] auxRatio;

  assign mainIdx      = srcSel[2:1];
  assign reservedCode = (srcSel == 3'b001);
  assign mainInv      = srcSel[0] && (mainIdx != '0);

  always_comb begin
    case (mainIdx)
      2'd0:    mainSrcOk = 1'b1;
      2'd1:    mainSrcOk = pllEn[0];
      2'd2:    mainSrcOk = pllEn[1];
      default: mainSrcOk = pllEn[2];
    endcase
    if (reservedCode) mainSrcOk = 1'b0;
  end

  always_comb begin
    case (auxSel)
      2'b01:   auxRatio = DIV_W'(4);
      2'b10:   auxRatio = DIV_W'(2);
      2'b11:   auxRatio = DIV_W'(3);
      default: auxRatio = '0;
    endcase
  end

  assign mainCmd = mkCmd(divVal, mainIdx, mainInv, mainSrcOk, rstN, outEn);
  assign auxCmd  = mkCmd(auxRatio, SEL_W'(1), 1'b0, pllEn[0], rstN, outEn);
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic [SRC_N-1:0] srcClk,
  input  logic             rstN,
  input  divCmd_t          cmd,
  output logic             divOut
);
  logic             rawClk;
  logic             selClk;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cntNext;
  logic             hiQ;
  logic             negQ;
  logic             freshQ;
  logic             shaped;

  assign rawClk = srcClk[cmd.srcIdx];
  assign selClk = rawClk ^ cmd.invert;

  always_comb begin
    if (freshQ)                  cntNext = '0;
    else if (cnt >= cmd.lastIdx) cntNext = '0;
    else                         cntNext = cnt + 1'b1;
  end

  always_ff @(posedge selClk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      hiQ    <= 1'b0;
      freshQ <= 1'b1;
    end else if (!cmd.run) begin
      cnt    <= '0;
      hiQ    <= 1'b0;
      freshQ <= 1'b1;
    end else begin
      cnt    <= cntNext;
      hiQ    <= (cntNext < cmd.halfCnt);
      freshQ <= 1'b0;
    end
  end

  // Half-period extension term for odd ratios
  always_ff @(negedge selClk or negedge rstN) begin
    if (!rstN) negQ <= 1'b0;
    else       negQ <= hiQ;
  end

  assign shaped = cmd.bypass ? selClk : (hiQ | (cmd.odd & negQ));
  assign divOut = cmd.oe & shaped;

  AST_CNT_RANGE: assert property (@(posedge selClk) disable iff (!rstN)
    (cmd.run && $past(cmd.run) && $stable(cmd.lastIdx)) |-> (cnt <= cmd.lastIdx)); // R1
  AST_HALF_TRACK: assert property (@(posedge selClk) disable iff (!rstN)
    (cmd.run && $past(cmd.run)) |-> (negQ == hiQ)); // R2
  AST_STOP_CLEAR: assert property (@(posedge selClk) disable iff (!rstN)
    (!cmd.run) |=> (!hiQ && cnt == '0)); // R3
  AST_FRESH_START: assert property (@(posedge selClk) disable iff (!rstN)
    (freshQ && cmd.run && !cmd.bypass) |=> (hiQ && cnt == '0)); // R9
endmodule

// File: rtl/clkdiv_channel.sv
`timescale 1ns/1ps
module clkdiv_channel
  import clkdiv_pkg::*;
(
  input  logic             refClk,
  input  logic             pll1Clk,
  input  logic             pll2Clk,
  input  logic             pll3Clk,
  input  logic             rstN,
  input  logic [PLL_N-1:0] pllEn,
  input  logic [2:0]       srcSel,
  input  logic [DIV_W-1:0] divVal,
  input  logic [1:0]       auxSel,
  input  logic             outEn,
  output logic             clkOut,
  output logic             clkOe,
  output logic             auxOut,
  output logic             auxOe
);
  localparam int CH_N = 2;

  logic [SRC_N-1:0] srcVec;
  divCmd_t          mainCmd;
  divCmd_t          auxCmd;
  divCmd_t [CH_N-1:0] cmdArr;
  logic [CH_N-1:0]  outVec;

  assign srcVec    = {pll3Clk, pll2Clk, pll1Clk, refClk};
  assign cmdArr[0] = mainCmd;
  assign cmdArr[1] = auxCmd;

  clkdiv_ctrl u_ctrl (
    .rstN   (rstN),
    .pllEn  (pllEn),
    .srcSel (srcSel),
    .divVal (divVal),
    .auxSel (auxSel),
    .outEn  (outEn),
    .mainCmd(mainCmd),
    .auxCmd (auxCmd)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    clkdiv_core u_core (
      .srcClk(srcVec),
      .rstN  (rstN),
      .cmd   (cmdArr[g]),
      .divOut(outVec[g])
    );
  end

  assign clkOut = outVec[0];
  assign auxOut = outVec[1];
  assign clkOe  = mainCmd.oe;
  assign auxOe  = auxCmd.oe;
endmodule

// File: tb/sim_clkdiv_channel.sv
`timescale 1ns/1ps
module sim_clkdiv_channel;
  logic refClk = 1'b0, pll1Clk = 1'b0, pll2Clk = 1'b0, pll3Clk = 1'b0;
  logic rstN;
  logic [2:0] pllEn;
  logic [2:0] srcSel;
  logic [6:0] divVal;
  logic [1:0] auxSel;
  logic outEn;
  logic clkOut, clkOe, auxOut, auxOe;

  int vecs = 0;
  int errs = 0;

  always #5 refClk  = ~refClk;   // 100 MHz
  always #3 pll1Clk = ~pll1Clk;
  always #4 pll2Clk = ~pll2Clk;
  always #7 pll3Clk = ~pll3Clk;

  clkdiv_channel u0 (
    .refClk(refClk), .pll1Clk(pll1Clk), .pll2Clk(pll2Clk), .pll3Clk(pll3Clk),
    .rstN(rstN), .pllEn(pllEn), .srcSel(srcSel), .divVal(divVal),
    .auxSel(auxSel), .outEn(outEn),
    .clkOut(clkOut), .clkOe(clkOe), .auxOut(auxOut), .auxOe(auxOe)
  );

  task automatic chk(input bit good, input string req, input real act, input real exp);
    vecs++;
    if (!good) begin
      errs++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", req, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  function automatic real srcPer(input logic [2:0] s);
    case (s[2:1])
      2'd0:    return 10.0;
      2'd1:    return 6.0;
      2'd2:    return 8.0;
      default: return 14.0;
    endcase
  endfunction

  function automatic logic rawSrc(input logic [2:0] s);
    case (s[2:1])
      2'd0:    return refClk;
      2'd1:    return pll1Clk;
      2'd2:    return pll2Clk;
      default: return pll3Clk;
    endcase
  endfunction

  task automatic waitLvl(input bit which, input logic v, output real t, inout bit ok);
    int g = 0;
    while (((which ? auxOut : clkOut) !== v) && g < 8000) begin
      #0.5;
      g++;
    end
    if (g >= 8000) ok = 1'b0;
    t = $realtime;
  endtask

  task automatic measure(input bit which, output real per, output real hi,
                         output logic lvl, output bit ok);
    real t0, r1, f1, r2;
    ok = 1'b1;
    waitLvl(which, 1'b0, t0, ok);
    waitLvl(which, 1'b1, t0, ok);
    waitLvl(which, 1'b0, t0, ok);
    waitLvl(which, 1'b1, r1, ok);
    lvl = rawSrc(srcSel);
    waitLvl(which, 1'b0, f1, ok);
    waitLvl(which, 1'b1, r2, ok);
    per = r2 - r1;
    hi  = f1 - r1;
  endtask

  task automatic toggles(input bit which, input int steps, output int n);
    logic prev = which ? auxOut : clkOut;
    n = 0;
    for (int i = 0; i < steps; i++) begin
      #0.5;
      if ((which ? auxOut : clkOut) !== prev) n++;
      prev = which ? auxOut : clkOut;
    end
  endtask

  task automatic setMain(input logic [2:0] s, input logic [6:0] n);
    divVal = '0;
    #20;
    srcSel = s;
    divVal = n;
  endtask

  task automatic setAux(input logic [1:0] a);
    auxSel = 2'b00;
    #20;
    auxSel = a;
  endtask

  task automatic sweepPoint(input logic [2:0] s, input int n);
    real per, hi, eper, ehi;
    logic lvl;
    bit ok;
    setMain(s, 7'(n));
    measure(1'b0, per, hi, lvl, ok);
    eper = srcPer(s) * n;
    ehi  = eper / 2.0;
    chk(ok, "R1", real'(ok), 1.0);
    chk(near(per, eper), "R1", per, eper);
    chk(near(hi, ehi), "R2", hi, ehi);
    chk(lvl === ~s[0] || s[2:1] == 2'd0 && lvl === 1'b1, "R4", real'(lvl), real'(~s[0]));
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    #1500000;
    errs++;
    vecs++;
    $display("FAIL R1 watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    real per, hi, tc, r0, f0;
    logic lvl;
    bit ok;
    int n;
    #0.25;
    rstN = 1'b0; pllEn = 3'b111; srcSel = 3'b000; divVal = 7'd3; auxSel = 2'b10; outEn = 1'b1;
    #20;
    // R10 reset state
    chk(clkOe === 1'b0, "R10", real'(clkOe), 0.0);
    chk(auxOe === 1'b0, "R10", real'(auxOe), 0.0);
    toggles(1'b0, 80, n);
    chk(n == 0 && clkOut === 1'b0, "R10", real'(n), 0.0);
    toggles(1'b1, 80, n);
    chk(n == 0 && auxOut === 1'b0, "R10", real'(n), 0.0);
    rstN = 1'b1;
    #20;

    // R1 R2 R4 full ratio sweep on reference and PLL1 inverted
    for (int k = 1; k <= 127; k++) sweepPoint(3'b000, k);
    for (int k = 1; k <= 127; k++) sweepPoint(3'b011, k);
    // R4 remaining sources, shorter range plus the top ratio
    for (int s = 2; s < 8; s++) begin
      if (s != 3) begin
        for (int k = 1; k <= 24; k++) sweepPoint(3'(s), k);
        sweepPoint(3'(s), 127);
      end
    end

    // R3 zero ratio
    setMain(3'b000, 7'd0);
    #1;
    chk(clkOe === 1'b0, "R3", real'(clkOe), 0.0);
    toggles(1'b0, 400, n);
    chk(n == 0 && clkOut === 1'b0, "R3", real'(n), 0.0);

    // R9 fresh start from off
    #40;
    tc = $realtime;
    divVal = 7'd5;
    ok = 1'b1;
    waitLvl(1'b0, 1'b1, r0, ok);
    chk(ok && (r0 - tc) <= 10.5, "R9", r0 - tc, 10.0);
    waitLvl(1'b0, 1'b0, f0, ok);
    chk(near(f0 - r0, 25.0), "R9", f0 - r0, 25.0);

    // R5 reserved code
    setMain(3'b001, 7'd3);
    #1;
    chk(clkOe === 1'b0, "R5", real'(clkOe), 0.0);
    toggles(1'b0, 400, n);
    chk(n == 0 && clkOut === 1'b0, "R5", real'(n), 0.0);

    // R6 output enable
    setMain(3'b010, 7'd4);
    #100;
    outEn = 1'b0;
    #1;
    chk(clkOe === 1'b0, "R6", real'(clkOe), 0.0);
    chk(auxOe === 1'b0, "R6", real'(auxOe), 0.0);
    toggles(1'b0, 200, n);
    chk(n == 0 && clkOut === 1'b0, "R6", real'(n), 0.0);
    toggles(1'b1, 200, n);
    chk(n == 0 && auxOut === 1'b0, "R6", real'(n), 0.0);
    outEn = 1'b1;
    #0.5;
    chk(clkOe === 1'b1, "R6", real'(clkOe), 1.0);
    measure(1'b0, per, hi, lvl, ok);
    chk(ok && near(per, 24.0), "R6", per, 24.0);
    chk(near(hi, 12.0), "R6", hi, 12.0);

    // R7 PLL disable
    divVal = '0;
    #20;
    pllEn = 3'b101;
    setMain(3'b100, 7'd3);
    #1;
    chk(clkOe === 1'b0, "R7", real'(clkOe), 0.0);
    toggles(1'b0, 200, n);
    chk(n == 0 && clkOut === 1'b0, "R7", real'(n), 0.0);
    divVal = '0;
    #20;
    pllEn = 3'b000;
    setMain(3'b000, 7'd3);
    #1;
    chk(clkOe === 1'b1, "R7", real'(clkOe), 1.0);
    measure(1'b0, per, hi, lvl, ok);
    chk(ok && near(per, 30.0), "R7", per, 30.0);
    chk(near(hi, 15.0), "R7", hi, 15.0);
    // R8 aux off when PLL1 disabled
    setAux(2'b11);
    #1;
    chk(auxOe === 1'b0, "R8", real'(auxOe), 0.0);
    toggles(1'b1, 200, n);
    chk(n == 0, "R8", real'(n), 0.0);
    pllEn = 3'b111;

    // R8 aux codes
    setAux(2'b00);
    #1;
    chk(auxOe === 1'b0, "R8", real'(auxOe), 0.0);
    toggles(1'b1, 200, n);
    chk(n == 0 && auxOut === 1'b0, "R8", real'(n), 0.0);
    for (int a = 1; a < 4; a++) begin
      real ep;
      ep = (a == 1) ? 24.0 : (a == 2) ? 12.0 : 18.0;
      setAux(2'(a));
      #1;
      chk(auxOe === 1'b1, "R8", real'(auxOe), 1.0);
      measure(1'b1, per, hi, lvl, ok);
      chk(ok && near(per, ep), "R8", per, ep);
      chk(near(hi, ep / 2.0), "R8", hi, ep / 2.0);
    end

    summary();
    $finish;
  end
endmodule